// File: doc/BRIEF.md
# Variable-Length JTAG Message Scan Register

This block is a JTAG data register that carries a message of up to eight 16-bit words between an external debug host and the chip. Each scan picks its own chain length. The register is reached only through the serial JTAG path. The processor bus has no access to it.

TDO is always taken from bit 0 of word 0, the lowest-addressed word. The point where TDI enters the chain moves with the chosen length. When fewer than eight words are chosen, only the low words of a buffer take part.

The instruction selects one of two scan types:

- **Receive scan:** the length comes from a 5-bit field carried with the instruction. On Update-DR the shifted-in message is written into the low words of a 128-bit receive buffer.
- **Transmit scan:** the length comes from a 5-bit message-length value in a transmit status register. On Capture-DR the low words of a 128-bit transmit buffer are loaded.

The TAP controller, the instruction register and the processor-side buffers are outside this block. The TAP state indications are plain level pins sampled on rising TCK. There is no streaming handshake at the block's edge, because JTAG timing is set by the host.

Top module: `jscan_msg_reg`

## Requirements
- R1: For a length value N of 0 to 6, the chain between TDI and TDO is exactly 16×(N+1) stages long. A bit driven on TDI first appears on TDO after that many shift edges.
- R2: Any length value N of 7 or above, up to 31, gives a chain of 128 stages (8 words).
- R3: When `sel_rx` is high, the length is taken from `rx_len` and `tx_len` is ignored. When `sel_tx` is high, the length is taken from `tx_len` and `rx_len` is ignored.
- R4: The length is sampled on the Capture-DR edge. Changes on `rx_len` or `tx_len` after that edge have no effect on the scan in progress.
- R5: On Capture-DR of a transmit scan, words 0 to W−1 of `tx_buf` are loaded into the chain, where W is the word count. They leave on TDO least significant bit first, starting with word 0 (bits 15:0 of `tx_buf`) and moving to higher words.
- R6: On Capture-DR of a receive scan, every active stage is cleared to 0.
- R7: On Update-DR of a receive scan, the chain contents are written to words 0 to W−1 of `rx_buf`. The bit that sits next to TDO lands in `rx_buf[0]`. Words W to 7 keep their previous values.
- R8: Update-DR during a transmit scan leaves `rx_buf` unchanged.
- R9: During Shift-DR the chain advances one stage toward TDO on each rising TCK edge. TDO changes only on falling TCK edges.
- R10: While `trst_n` is low, `rx_buf`, TDO and the chain are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | JTAG test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tdi | input | 1 | Serial data in |
| capture_dr | input | 1 | TAP is in Capture-DR with this register selected |
| shift_dr | input | 1 | TAP is in Shift-DR |
| update_dr | input | 1 | TAP is in Update-DR |
| sel_rx | input | 1 | Current instruction is a receive scan |
| sel_tx | input | 1 | Current instruction is a transmit scan |
| rx_len | input | 5 | Length field of the receive instruction, bit 4 is the MSB |
| tx_len | input | 5 | Message-length value from the transmit status register |
| tx_buf | input | 128 | Transmit buffer, word k at bits 16k+15:16k |
| rx_buf | output | 128 | Receive buffer, word k at bits 16k+15:16k |
| tdo | output | 1 | Serial data out, updated on falling TCK |

## Verification
The hardest thing to observe from the ports is where TDI enters the chain. During a normal scan, TDO only ever shows captured data. To expose it, the stimulus runs every scan 16 edges past the chain length and checks that the first TDI bits come back on TDO after exactly 16×W edges.

Each length value from 0 to 31 is swept for both scan types. While a scan is running, the unused length input carries a different value. Right after capture, both length inputs are changed again, so that sampling the length too late or from the wrong source moves the insertion point visibly. Word preservation is shown by comparing the whole receive buffer against a model after every update, including the updates issued during transmit scans.

// File: rtl/jscan_pkg.sv
package jscan_pkg;
  typedef enum logic [1:0] {
    SCAN_IDLE = 2'd0,
    SCAN_RX   = 2'd1,
    SCAN_TX   = 2'd2
  } scan_mode_e;
endpackage

// File: rtl/jscan_len_sel.sv
// Picks the length source for the instruction and clamps the word count.
module jscan_len_sel #(
  parameter int LEN_W     = 5,
  parameter int MAX_WORDS = 8,
  parameter int CNT_W     = $clog2(MAX_WORDS + 1)
) (
  input  logic             use_tx,
  input  logic [LEN_W-1:0] rx_len,
  input  logic [LEN_W-1:0] tx_len,
  output logic [CNT_W-1:0] words
);
  logic [LEN_W-1:0] n_sel;

  assign n_sel = use_tx ? tx_len : rx_len;

  always_comb begin
    if (32'(n_sel) >= 32'(MAX_WORDS - 1)) words = CNT_W'(MAX_WORDS);
    else                                  words = CNT_W'(n_sel) + CNT_W'(1);
  end
endmodule

// File: rtl/jscan_word_cell.sv
// One 16-bit slice of the chain, plus the receive word it updates.
module jscan_word_cell #(
  parameter int WORD_W = 16
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              active,
  input  logic              cap_en,
  input  logic              shift_en,
  input  logic              upd_en,
  input  logic [WORD_W-1:0] load_val,
  input  logic              top_bit,
  output logic              lsb,
  output logic [WORD_W-1:0] rx_word
);
  logic [WORD_W-1:0] sr;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sr <= '0;
    end else if (active) begin
      if (cap_en)        sr <= load_val;
      else if (shift_en) sr <= {top_bit, sr[WORD_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                rx_word <= '0;
    else if (upd_en && active)  rx_word <= sr;
  end

  assign lsb = sr[0];

  AST_RX_WORD_KEEP: assert property (@(posedge tck) disable iff (!trst_n)
    !(upd_en && active) |=> $stable(rx_word)); // R7
endmodule

// File: rtl/jscan_tdo_stage.sv
// Retimes the fixed chain end onto the falling TCK edge.
module jscan_tdo_stage (
  input  logic tck,
  input  logic trst_n,
  input  logic d,
  output logic q
);
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) q <= 1'b0;
    else         q <= d;
  end

  AST_TDO_FALL: assert property (@(posedge tck) disable iff (!trst_n)
    q == d); // R9
endmodule

// File: rtl/jscan_msg_reg.sv
module jscan_msg_reg #(
  parameter int WORD_W    = 16,
  parameter int MAX_WORDS = 8,
  parameter int LEN_W     = 5,
  localparam int BUF_W    = WORD_W * MAX_WORDS,
  localparam int CNT_W    = $clog2(MAX_WORDS + 1)
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tdi,
  input  logic             capture_dr,
  input  logic             shift_dr,
  input  logic             update_dr,
  input  logic             sel_rx,
  input  logic             sel_tx,
  input  logic [LEN_W-1:0] rx_len,
  input  logic [LEN_W-1:0] tx_len,
  input  logic [BUF_W-1:0] tx_buf,
  output logic [BUF_W-1:0] rx_buf,
  output logic             tdo
);
  import jscan_pkg::*;

  scan_mode_e       mode, mode_nx;
  logic [CNT_W-1:0] act_words, cap_words;
  logic [MAX_WORDS:0] link;
  logic             cap_en, shift_en, upd_en;

  jscan_len_sel #(.LEN_W(LEN_W), .MAX_WORDS(MAX_WORDS), .CNT_W(CNT_W)) u_len (
    .use_tx (sel_tx),
    .rx_len (rx_len),
    .tx_len (tx_len),
    .words  (cap_words)
  );

  always_comb begin
    if (sel_tx)      mode_nx = SCAN_TX;
    else if (sel_rx) mode_nx = SCAN_RX;
    else             mode_nx = SCAN_IDLE;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      mode      <= SCAN_IDLE;
      act_words <= CNT_W'(1);
    end else if (capture_dr) begin
      mode      <= mode_nx;
      act_words <= cap_words;
    end
  end

  assign cap_en   = capture_dr && (mode_nx != SCAN_IDLE);
  assign shift_en = shift_dr && !capture_dr && (mode != SCAN_IDLE);
  assign upd_en   = update_dr && (mode == SCAN_RX);
  assign link[MAX_WORDS] = tdi;

  for (genvar k = 0; k < MAX_WORDS; k++) begin : g_word
    logic              active, top_bit;
    logic [WORD_W-1:0] load_val;

    assign active   = capture_dr ? (CNT_W'(k) < cap_words) : (CNT_W'(k) < act_words);
    assign top_bit  = (CNT_W'(k + 1) == act_words) ? tdi : link[k+1];
    assign load_val = (mode_nx == SCAN_TX) ? tx_buf[k*WORD_W +: WORD_W] : '0;

    jscan_word_cell #(.WORD_W(WORD_W)) u_cell (
      .tck      (tck),
      .trst_n   (trst_n),
      .active   (active),
      .cap_en   (cap_en),
      .shift_en (shift_en),
      .upd_en   (upd_en),
      .load_val (load_val),
      .top_bit  (top_bit),
      .lsb      (link[k]),
      .rx_word  (rx_buf[k*WORD_W +: WORD_W])
    );
  end

  jscan_tdo_stage u_tdo (
    .tck    (tck),
    .trst_n (trst_n),
    .d      (link[0]),
    .q      (tdo)
  );

  AST_LEN_RANGE: assert property (@(posedge tck) disable iff (!trst_n)
    (act_words >= CNT_W'(1)) && (act_words <= CNT_W'(MAX_WORDS))); // R2
  AST_LEN_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
    !capture_dr |=> $stable(act_words)); // R4
  AST_TX_NO_WRITE: assert property (@(posedge tck) disable iff (!trst_n)
    (update_dr && mode == SCAN_TX) |=> $stable(rx_buf)); // R8
endmodule

// File: tb/jscan_msg_reg_test.sv
module jscan_msg_reg_test;
  logic         tck = 1'b0;
  logic         trst_n = 1'b0;
  logic         tdi = 1'b0, capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
  logic         sel_rx = 1'b0, sel_tx = 1'b0;
  logic [4:0]   rx_len = '0, tx_len = '0;
  logic [127:0] tx_buf = '0;
  logic [127:0] rx_buf;
  logic         tdo;

  int errors = 0, checks = 0;
  bit exp_q[$];
  bit mon_en = 1'b0;
  bit last_exp = 1'b0;
  string cur_req = "R5";
  logic [127:0] rx_model = '0;

  always #2.5 tck = ~tck;

  jscan_msg_reg uut (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .sel_rx(sel_rx), .sel_tx(sel_tx),
    .rx_len(rx_len), .tx_len(tx_len), .tx_buf(tx_buf), .rx_buf(rx_buf), .tdo(tdo)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops the expected TDO bit after each falling edge
  always @(negedge tck) begin
    #2;
    if (mon_en) begin
      last_exp = exp_q.pop_front();
      chk(tdo === last_exp, cur_req, 128'(tdo), 128'(last_exp));
    end
  end

  // R9: TDO must still hold the same bit just after the rising edge
  always @(posedge tck) begin
    #1;
    if (mon_en) chk(tdo === last_exp, "R9", 128'(tdo), 128'(last_exp));
  end

  task automatic do_scan(input bit is_tx, input int n);
    int w, nb, s;
    logic [127:0] txv;
    logic [143:0] d;
    w  = (n >= 7) ? 8 : n + 1;
    nb = 16 * w;
    s  = nb + 16;
    txv = {$urandom, $urandom, $urandom, $urandom};
    d   = {$urandom, $urandom, $urandom, $urandom, $urandom};
    // R1 R2 below 128 stages vs clamp; R3 other length input differs
    cur_req = (n >= 7) ? "R2" : "R1";
    @(negedge tck); #1;
    tx_buf = txv;
    sel_tx = is_tx; sel_rx = !is_tx;
    if (is_tx) begin tx_len = 5'(n); rx_len = 5'(n + 9); end
    else       begin rx_len = 5'(n); tx_len = 5'(n + 9); end
    capture_dr = 1'b1;
    @(negedge tck); #1;
    capture_dr = 1'b0;
    rx_len = 5'($urandom); tx_len = 5'($urandom);   // R4
    for (int j = 0; j < s; j++) begin
      if (j > 0) begin @(negedge tck); #1; end
      if (j < nb) exp_q.push_back(is_tx ? txv[j] : 1'b0);  // R5 / R6
      else        exp_q.push_back(d[j - nb]);              // R1 / R2 / R3
      shift_dr = 1'b1; tdi = d[j]; mon_en = 1'b1;
    end
    @(negedge tck); #1;
    shift_dr = 1'b0; mon_en = 1'b0; update_dr = 1'b1;
    @(negedge tck); #1;
    update_dr = 1'b0; sel_tx = 1'b0; sel_rx = 1'b0;
    if (!is_tx)
      for (int k = 0; k < w; k++) rx_model[16*k +: 16] = d[16 + 16*k +: 16];
    chk(rx_buf === rx_model, is_tx ? "R8" : "R7", rx_buf, rx_model);
  endtask

  initial begin
    #(5 * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge tck);
    #1;
    chk(tdo === 1'b0, "R10", 128'(tdo), 128'h0);
    chk(rx_buf === '0, "R10", rx_buf, '0);
    trst_n = 1'b1;
    for (int n = 0; n < 32; n++) begin
      do_scan(1'b0, n);
      do_scan(1'b1, n);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule